// File: doc/BRIEF.md
# IF Edge-Count Frequency-to-Digital Demodulator

This block turns a limited intermediate-frequency (IF) square wave into digital samples of its instantaneous frequency. Everything runs on one system clock, and two single-cycle enables carry the timing. One enable marks each IF edge. The other marks each edge of a much slower reference clock. A saturating counter tallies IF edges. On every reference pulse, that same pulse copies the tally into the newest stage of a delay line and restarts the counter. Each raw sample is therefore the number of IF edges seen in one reference interval.

The delay line keeps the most recent `TAPS` samples, and a moving-sum filter smooths them. Rather than instantiate a wide adder tree, a single adder walks through the taps, one per system cycle, in the cycles that follow a reference pulse. A result is produced only on every `DECIM`-th reference pulse. Output words therefore leave at a regular decimated rate tied to the reference clock, with a one-cycle valid strobe, and no interpolation stage is needed.

If the IF deviation is too small to change the edge tally, the output simply stays constant. A sticky flag reports a reference pulse that arrives before the serial sum has finished.

Top module: `ifcnt_demod`

## Requirements
- R1: While reset is applied, and until the first reference pulse after it, `raw_count`, `data_out`, `data_valid` and `overrun_err` are all zero.
- R2: The system cycle after a reference pulse, `raw_count` shows the number of IF edge enables seen since the previous reference pulse (or since reset). It holds that value until the next reference pulse.
- R3: An IF edge enable that coincides with a reference pulse belongs to the new interval. The counter restarts at one, so that edge is included in the next sample and not in the one being latched.
- R4: The edge counter saturates at 2^CNT_W-1 and does not wrap, however many IF edges an interval contains.
- R5: After a triggering reference pulse, `data_out` becomes the sum of the latest `TAPS` samples, including the one latched by that pulse. `data_valid` goes high for exactly one cycle, `TAPS`+1 cycles after the cycle that held the pulse.
- R6: A summation starts only on reference pulses whose index since reset is a multiple of `DECIM` (the `DECIM`-th, the 2·`DECIM`-th, and so on). The pulse must also find the delay line filled with at least `TAPS` samples since reset. No other pulse ever produces `data_valid`.
- R7: A constant IF edge rate gives identical successive output words once the delay line holds only full intervals.
- R8: A reference pulse that arrives while a summation is in progress sets `overrun_err`, which stays set until reset. The interrupted sum is abandoned without raising `data_valid`. If that pulse is itself a triggering pulse, a fresh summation starts.
- R9: The output is CNT_W+ceil(log2 TAPS) bits wide, and a sum of `TAPS` saturated samples is delivered exactly, without overflow.
- R10: `data_out` changes only in a cycle where `data_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| if_edge_en | input | 1 | One-cycle enable marking an edge of the limited IF signal |
| ref_edge_en | input | 1 | One-cycle enable marking an edge of the slow reference clock |
| raw_count | output | CNT_W | Most recently latched IF edge tally |
| data_out | output | CNT_W+ceil(log2 TAPS) | Filtered moving-sum output word |
| data_valid | output | 1 | One-cycle strobe when `data_out` is updated |
| overrun_err | output | 1 | Sticky flag: reference pulse during an unfinished summation |

## Verification
Two events can share one cycle, and the bench drives both on purpose. The first is an IF edge enable landing together with a reference pulse: an even IF edge period with an even reference period makes them coincide repeatedly. The bench then judges each latched tally, and each later sum, against a behavioural model that credits the edge to the new interval. The second is a reference pulse landing while the serial adder is still stepping through the taps: a reference period shorter than `TAPS`+1 cycles provokes it. Here the model expects the sticky error, no strobe for the interrupted sum, and a restart when the new pulse is a triggering one.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  // Width of an index or counter able to address n distinct values (at least 1 bit).
  function automatic int unsigned ptr_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Accumulator width for a sum of taps entries of cnt_w bits.
  function automatic int unsigned sum_w(input int unsigned cnt_w, input int unsigned taps);
    return cnt_w + ((taps > 1) ? $clog2(taps) : 0);
  endfunction
endpackage

// File: rtl/ifd_edge_counter.sv
module ifd_edge_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_edge_en,
  input  logic             ref_edge_en,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ref_edge_en) begin
      // Shared load/clear pulse; a coincident IF edge opens the new interval.
      cnt_d = if_edge_en ? CNT_W'(1) : '0;
    end else if (if_edge_en && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ifd_tap_line.sv
module ifd_tap_line #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TAPS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_edge_en,
  input  logic [CNT_W-1:0]           cnt_i,
  output logic [TAPS-1:0][CNT_W-1:0] taps_o
);
  logic [TAPS-1:0][CNT_W-1:0] taps_q, taps_d;

  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    logic [CNT_W-1:0] src;
    if (g == 0) begin : g_head
      assign src = cnt_i;
    end else begin : g_body
      assign src = taps_q[g-1];
    end

    always_comb begin
      taps_d[g] = ref_edge_en ? src : taps_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps_q[g] <= '0;
      else        taps_q[g] <= taps_d[g];
    end
  end

  assign taps_o = taps_q;
endmodule

// File: rtl/ifd_serial_sum.sv
module ifd_serial_sum
  import ifd_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TAPS  = 4,
  parameter int unsigned DECIM = 4,
  localparam int unsigned ACC_W  = sum_w(CNT_W, TAPS),
  localparam int unsigned IDX_W  = ptr_w(TAPS),
  localparam int unsigned PH_W   = ptr_w(DECIM),
  localparam int unsigned FILL_W = $clog2(TAPS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_edge_en,
  input  logic [TAPS-1:0][CNT_W-1:0] taps_i,
  output logic [ACC_W-1:0]           data_o,
  output logic                       valid_o,
  output logic                       busy_o,
  output logic                       overrun_o
);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(TAPS - 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(DECIM - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(TAPS);
  localparam logic [FILL_W-1:0] FILL_PRE  = FILL_W'(TAPS - 1);

  logic [FILL_W-1:0] fill_q, fill_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [ACC_W-1:0]  data_q, data_d;
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic [ACC_W-1:0]  add_w;
  logic              slot_w, start_w;

  assign slot_w  = (ph_q == PH_LAST);
  assign start_w = ref_edge_en && slot_w && (fill_q >= FILL_PRE);
  assign add_w   = acc_q + ACC_W'(taps_i[idx_q]);

  always_comb begin
    fill_d  = fill_q;
    ph_d    = ph_q;
    busy_d  = busy_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    data_d  = data_q;
    valid_d = 1'b0;
    err_d   = err_q;

    if (ref_edge_en) begin
      if (fill_q != FILL_FULL) fill_d = fill_q + 1'b1;
      ph_d = slot_w ? '0 : ph_q + 1'b1;
    end

    // One tap per cycle through the single adder.
    if (busy_q) begin
      if (idx_q == IDX_LAST) begin
        data_d  = add_w;
        valid_d = 1'b1;
        busy_d  = 1'b0;
      end else begin
        acc_d = add_w;
        idx_d = idx_q + 1'b1;
      end
    end

    // A reference pulse during a running sum abandons it.
    if (ref_edge_en && busy_q) begin
      err_d   = 1'b1;
      busy_d  = 1'b0;
      valid_d = 1'b0;
      data_d  = data_q;
    end

    if (start_w) begin
      busy_d = 1'b1;
      idx_d  = '0;
      acc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      ph_q    <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      acc_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      fill_q  <= fill_d;
      ph_q    <= ph_d;
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      acc_q   <= acc_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign busy_o    = busy_q;
  assign overrun_o = err_q;
endmodule

// File: rtl/ifcnt_demod.sv
module ifcnt_demod
  import ifd_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TAPS  = 4,
  parameter int unsigned DECIM = 4,
  localparam int unsigned ACC_W = sum_w(CNT_W, TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_edge_en,
  input  logic             ref_edge_en,
  output logic [CNT_W-1:0] raw_count,
  output logic [ACC_W-1:0] data_out,
  output logic             data_valid,
  output logic             overrun_err
);
  logic [1:0]                 rst_sync_q;
  logic                       rst_int_n;
  logic [CNT_W-1:0]           live_cnt;
  logic [TAPS-1:0][CNT_W-1:0] taps;
  logic                       sum_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ifd_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .if_edge_en  (if_edge_en),
    .ref_edge_en (ref_edge_en),
    .cnt_o       (live_cnt)
  );

  ifd_tap_line #(.CNT_W(CNT_W), .TAPS(TAPS)) u_taps (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ref_edge_en (ref_edge_en),
    .cnt_i       (live_cnt),
    .taps_o      (taps)
  );

  ifd_serial_sum #(.CNT_W(CNT_W), .TAPS(TAPS), .DECIM(DECIM)) u_sum (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ref_edge_en (ref_edge_en),
    .taps_i      (taps),
    .data_o      (data_out),
    .valid_o     (data_valid),
    .busy_o      (sum_busy),
    .overrun_o   (overrun_err)
  );

  assign raw_count = taps[0];
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned ACC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             if_edge_en,
  input logic             ref_edge_en,
  input logic [CNT_W-1:0] raw_count,
  input logic [ACC_W-1:0] data_out,
  input logic             data_valid,
  input logic             overrun_err,
  input logic [CNT_W-1:0] live_cnt,
  input logic             sum_busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2: latched tally moves only on a reference pulse
  p_raw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_edge_en |=> $stable(raw_count));

  // R3: coincident IF edge restarts the tally at one
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge_en && if_edge_en) |=> (live_cnt == CNT_W'(1)));

  // R4: saturated counter stays at its ceiling
  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_edge_en && live_cnt == CNT_MAX) |=> (live_cnt == CNT_MAX));

  // R5: strobe is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R8: error flag is sticky
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> overrun_err);

  // R8: pulse during a running sum raises the flag
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge_en && sum_busy) |=> overrun_err);

  // R10: output word changes only with the strobe
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> data_valid);
endmodule

bind ifcnt_demod ifd_checker #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .if_edge_en  (if_edge_en),
  .ref_edge_en (ref_edge_en),
  .raw_count   (raw_count),
  .data_out    (data_out),
  .data_valid  (data_valid),
  .overrun_err (overrun_err),
  .live_cnt    (live_cnt),
  .sum_busy    (sum_busy)
);

// File: tb/tb_ifcnt_demod.sv
module tb_ifcnt_demod;
  localparam int CNT_W = 6;
  localparam int TAPS  = 4;
  localparam int DECIM = 4;
  localparam int ACC_W = CNT_W + $clog2(TAPS);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             if_edge_en = 1'b0;
  logic             ref_edge_en = 1'b0;
  logic [CNT_W-1:0] raw_count;
  logic [ACC_W-1:0] data_out;
  logic             data_valid;
  logic             overrun_err;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ifcnt_demod #(.CNT_W(CNT_W), .TAPS(TAPS), .DECIM(DECIM)) dut (
    .clk(clk), .rst_n(rst_n), .if_edge_en(if_edge_en), .ref_edge_en(ref_edge_en),
    .raw_count(raw_count), .data_out(data_out), .data_valid(data_valid),
    .overrun_err(overrun_err)
  );

  // Behavioural reference model
  int q[$];
  int m_cnt, m_fill, m_phase, m_busy_left, m_pend, m_data;
  bit m_valid, m_err;

  task automatic model_reset();
    q.delete();
    m_cnt = 0; m_fill = 0; m_phase = 0; m_busy_left = 0;
    m_pend = 0; m_data = 0; m_valid = 0; m_err = 0;
  endtask

  always @(posedge clk) begin
    cycle++;
    if (!rst_n) begin
      model_reset();
    end else begin
      bit was_busy;
      was_busy = (m_busy_left > 0);
      m_valid = 0;
      if (ref_edge_en && was_busy) begin
        m_err = 1;
        m_busy_left = 0;
      end else if (was_busy) begin
        m_busy_left--;
        if (m_busy_left == 0) begin
          m_valid = 1;
          m_data = m_pend;
        end
      end
      if (ref_edge_en) begin
        bit slot;
        q.push_front(m_cnt);
        if (q.size() > TAPS) void'(q.pop_back());
        if (m_fill < TAPS) m_fill++;
        slot = (m_phase == DECIM - 1);
        m_phase = slot ? 0 : m_phase + 1;
        if (slot && m_fill == TAPS) begin
          m_pend = 0;
          foreach (q[i]) m_pend += q[i];
          m_busy_left = TAPS;
        end
        m_cnt = if_edge_en ? 1 : 0;
      end else if (if_edge_en && m_cnt < CMAX) begin
        m_cnt++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cycle);
    end
  endtask

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 raw_count", int'(raw_count), (q.size() > 0) ? q[0] : 0);
      check("R6 data_valid", int'(data_valid), int'(m_valid));
      check("R5 data_out", int'(data_out), m_data);
      check("R8 overrun_err", int'(overrun_err), int'(m_err));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycle > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired cycle=%0d", cycle);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; if_edge_en = 1'b0; ref_edge_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 raw_count", int'(raw_count), 0);
    check("R1 data_out", int'(data_out), 0);
    check("R1 data_valid", int'(data_valid), 0);
    check("R1 overrun_err", int'(overrun_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Periodic stimulus; if_per 0 selects a pseudo-random IF edge pattern.
  // Returns the list of output words seen.
  task automatic run(input int if_per, input int ref_per, input int n_cyc,
                     output int outs[$]);
    int lcg = 12345;
    outs.delete();
    for (int c = 1; c <= n_cyc; c++) begin
      if (if_per == 0) begin
        lcg = lcg * 1103515245 + 12345;
        if_edge_en = ((lcg >>> 16) & 3) != 0;
      end else begin
        if_edge_en = (c % if_per) == 0;
      end
      ref_edge_en = (c % ref_per) == 0;
      @(negedge clk);
      if (data_valid) outs.push_back(int'(data_out));
    end
    if_edge_en = 1'b0;
    ref_edge_en = 1'b0;
  endtask

  initial begin
    int outs[$];

    // Main function, odd-sized intervals
    apply_reset();
    run(3, 20, 600, outs);
    check("R6 outputs produced", int'(outs.size() >= 5), 1);

    // R7: constant rate gives constant word (skip the first, partial output)
    apply_reset();
    run(4, 20, 800, outs);
    check("R7 output count", int'(outs.size() >= 8), 1);
    for (int i = 1; i < outs.size(); i++) check("R7 constant word", outs[i], TAPS * 5);

    // R3: IF edges coincide with every reference pulse
    apply_reset();
    run(2, 20, 600, outs);
    for (int i = 1; i < outs.size(); i++) check("R3 coincident edge sum", outs[i], TAPS * 10);

    // Irregular IF edge pattern
    apply_reset();
    run(0, 17, 1200, outs);

    // R4 and R9: saturated tallies, full-scale sum
    apply_reset();
    run(1, 80, 1300, outs);
    check("R4 raw saturated", int'(raw_count), CMAX);
    check("R9 output count", int'(outs.size() >= 3), 1);
    for (int i = 0; i < outs.size(); i++) check("R9 full-scale sum", outs[i], TAPS * CMAX);

    // R8: reference pulses closer than the summation length
    apply_reset();
    run(2, 20, 200, outs);
    run(1, 3, 120, outs);
    check("R8 sticky flag", int'(overrun_err), 1);
    run(3, 20, 400, outs);
    check("R8 flag still set", int'(overrun_err), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule